// File: doc/BRIEF.md
# Stereo Oversampled-to-Audio-Rate Decimator

This block takes a stereo stream that runs at 128 times the audio output rate and lowers it to one sample per channel per output period. Each input strobe carries one left and one right sample. Internally the two channels share a single datapath. The right sample is held for one cycle, and a channel tag travels with every sample through the stages.

The first stage is a third-order comb-integrator (sinc) decimator by 16. It is followed by three half-band FIR stages, and each of these halves the rate again. Every half-band stage uses an 11-tap symmetric set with a 0.5 centre tap and zero taps at the other even offsets from the centre. A first-order DC-blocking high-pass filter sits at the very front. A control input bypasses it. The filter has to stay enabled whenever a gain-control loop downstream is running.

The result is saturated to a 24-bit signed value. It is presented as a left/right pair with a single-cycle valid pulse.

Top module: `deci_chain`

## Requirements
- R1: During and straight after reset, out_valid_o is 0 and out_l_o and out_r_o are 0.
- R2: out_valid_o pulses high for exactly one cycle once per 128 accepted input strobes. The first pulse follows the 128th strobe after reset.
- R3: The pulse comes with the seventh rising edge after the edge that samples the 128th strobe of each block.
- R4: With dc_bypass_i = 1, a constant input level reaches both outputs unchanged once settled (unity DC gain, 24-bit two's complement, full scale included).
- R5: With dc_bypass_i = 0, a constant input of any level settles to an output whose magnitude is at most 300 codes.
- R6: With the bypass set, an input whose sign alternates on every strobe (a tone at the input Nyquist rate) settles to an output of exactly 0.
- R7: Outputs clamp to the range -8388608 to 8388607 and never wrap. After a full-scale step, an output that has crossed zero toward the new level does not change sign again.
- R8: Left and right are processed independently. Within every stage the right sample of a pair directly follows its left sample, and the two levels never mix.
- R9: in_valid_i strobes are separated by at least one idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dc_bypass_i | input | 1 | 1 skips the DC-blocking filter |
| in_valid_i | input | 1 | Input strobe at 128x the output rate |
| in_l_i | input | IN_W | Left input sample, signed |
| in_r_i | input | IN_W | Right input sample, signed |
| out_valid_o | output | 1 | One-cycle pulse per output pair |
| out_l_o | output | OUT_W | Left output sample, saturated, signed |
| out_r_o | output | OUT_W | Right output sample, saturated, signed |

## Verification
The output pair is due on the seventh rising edge after the strobe that completes each block of 128. The bench records the time of every such strobe and checks that the pulse is seen at the falling edge exactly eight clock periods later. It also checks that the total pulse count equals the strobe count divided by 128.

Level checks are made only after each input pattern has been held for 4096 strobes. That is well beyond the settling of the filter cascade and the shortened DC-filter time constant used on the bench. The value checked is the last pair captured on a pulse, read ten cycles after the final strobe of the pattern.

// File: rtl/deci_pkg.sv
package deci_pkg;
  localparam int HB_NTAP  = 11;
  localparam int HB_SHIFT = 9;   // coefficient sum = 2**HB_SHIFT
  localparam int HB_GROW  = 12;

  function automatic int hb_coef(input int k);
    case (k)
      0, 10:   return 3;
      2, 8:    return -25;
      4, 6:    return 150;
      5:       return 256;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/deci_dc_hpf.sv
module deci_dc_hpf #(
  parameter int IW    = 24,
  parameter int OW    = 26,
  parameter int SHIFT = 14
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bypass_i,
  input  logic                 vld_i,
  input  logic                 ch_i,
  input  logic signed [IW-1:0] dat_i,
  output logic                 vld_o,
  output logic                 ch_o,
  output logic signed [OW-1:0] dat_o
);
  logic signed [OW-1:0] x1_q [2];
  logic signed [OW-1:0] y1_q [2];
  logic signed [OW-1:0] x_ext, y_new;

  always_comb begin
    x_ext = {{(OW-IW){dat_i[IW-1]}}, dat_i};
    // y = x - x[-1] + y[-1] * (1 - 2^-SHIFT)
    y_new = x_ext - x1_q[ch_i] + y1_q[ch_i] - (y1_q[ch_i] >>> SHIFT);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < 2; c++) begin
        x1_q[c] <= '0;
        y1_q[c] <= '0;
      end
      vld_o <= 1'b0;
      ch_o  <= 1'b0;
      dat_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        x1_q[ch_i] <= x_ext;
        y1_q[ch_i] <= y_new;
        ch_o       <= ch_i;
        dat_o      <= bypass_i ? x_ext : y_new;
      end
    end
  end
endmodule

// File: rtl/deci_cic.sv
module deci_cic #(
  parameter int W     = 26,
  parameter int RATIO = 16,
  parameter int ORDER = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                vld_i,
  input  logic                ch_i,
  input  logic signed [W-1:0] dat_i,
  output logic                vld_o,
  output logic                ch_o,
  output logic signed [W-1:0] dat_o
);
  localparam int LR = $clog2(RATIO);
  localparam int SH = ORDER * LR;
  localparam int CW = W + SH;

  logic signed [CW-1:0] integ_q [ORDER][2];
  logic signed [CW-1:0] comb_q  [ORDER][2];
  logic [LR-1:0]        phase_q;
  logic signed [CW-1:0] acc [ORDER+1];
  logic signed [CW-1:0] dif [ORDER+1];
  logic signed [CW-1:0] shr;

  always_comb begin
    acc[0] = {{SH{dat_i[W-1]}}, dat_i};
    for (int k = 0; k < ORDER; k++) acc[k+1] = integ_q[k][ch_i] + acc[k];
    dif[0] = acc[ORDER];
    for (int k = 0; k < ORDER; k++) dif[k+1] = dif[k] - comb_q[k][ch_i];
    shr = dif[ORDER] >>> SH;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < ORDER; k++)
        for (int c = 0; c < 2; c++) begin
          integ_q[k][c] <= '0;
          comb_q[k][c]  <= '0;
        end
      phase_q <= '0;
      vld_o   <= 1'b0;
      ch_o    <= 1'b0;
      dat_o   <= '0;
    end else begin
      vld_o <= 1'b0;
      if (vld_i) begin
        for (int k = 0; k < ORDER; k++) integ_q[k][ch_i] <= acc[k+1];
        if (ch_i) phase_q <= phase_q + 1'b1;
        if (phase_q == LR'(RATIO-1)) begin
          for (int k = 0; k < ORDER; k++) comb_q[k][ch_i] <= dif[k];
          vld_o <= 1'b1;
          ch_o  <= ch_i;
          dat_o <= shr[W-1:0];
        end
      end
    end
  end

  p_cic_pair_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && ch_o) |-> $past(vld_o && !ch_o));
endmodule

// File: rtl/deci_halfband.sv
module deci_halfband
  import deci_pkg::*;
#(
  parameter int W = 26
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                vld_i,
  input  logic                ch_i,
  input  logic signed [W-1:0] dat_i,
  output logic                vld_o,
  output logic                ch_o,
  output logic signed [W-1:0] dat_o
);
  localparam int PW = W + HB_GROW;

  logic signed [W-1:0]  dl_q [HB_NTAP-1][2];
  logic signed [W-1:0]  win  [HB_NTAP];
  logic signed [PW-1:0] acc, shr;
  logic                 phase_q;

  always_comb begin
    win[0] = dat_i;
    for (int k = 1; k < HB_NTAP; k++) win[k] = dl_q[k-1][ch_i];
    acc = '0;
    for (int k = 0; k < HB_NTAP; k++)
      if (hb_coef(k) != 0)
        acc = acc + PW'(win[k]) * PW'(hb_coef(k));
    shr = acc >>> HB_SHIFT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < HB_NTAP-1; k++)
        for (int c = 0; c < 2; c++) dl_q[k][c] <= '0;
      phase_q <= 1'b0;
      vld_o   <= 1'b0;
      ch_o    <= 1'b0;
      dat_o   <= '0;
    end else begin
      vld_o <= 1'b0;
      if (vld_i) begin
        dl_q[0][ch_i] <= dat_i;
        for (int k = 1; k < HB_NTAP-1; k++) dl_q[k][ch_i] <= dl_q[k-1][ch_i];
        if (ch_i) phase_q <= ~phase_q;
        if (phase_q) begin
          vld_o <= 1'b1;
          ch_o  <= ch_i;
          dat_o <= shr[W-1:0];
        end
      end
    end
  end

  p_hb_pair_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && ch_o) |-> $past(vld_o && !ch_o));
endmodule

// File: rtl/deci_chain.sv
module deci_chain #(
  parameter int IN_W     = 24,
  parameter int OUT_W    = 24,
  parameter int DC_SHIFT = 14,
  parameter int CIC_R    = 16,
  parameter int CIC_N    = 3,
  parameter int NUM_HB   = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    dc_bypass_i,
  input  logic                    in_valid_i,
  input  logic signed [IN_W-1:0]  in_l_i,
  input  logic signed [IN_W-1:0]  in_r_i,
  output logic                    out_valid_o,
  output logic signed [OUT_W-1:0] out_l_o,
  output logic signed [OUT_W-1:0] out_r_o
);
  localparam int DW = IN_W + 2;
  localparam logic signed [DW-1:0] SAT_HI = DW'(2**(OUT_W-1) - 1);
  localparam logic signed [DW-1:0] SAT_LO = ~SAT_HI;

  function automatic logic signed [OUT_W-1:0] sat(input logic signed [DW-1:0] x);
    if (x > SAT_HI) return SAT_HI[OUT_W-1:0];
    if (x < SAT_LO) return SAT_LO[OUT_W-1:0];
    return x[OUT_W-1:0];
  endfunction

  // time-multiplex: left on strobe+1, right on strobe+2
  logic                   s0_vld, s0_ch;
  logic signed [IN_W-1:0] s0_dat, r_hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s0_vld   <= 1'b0;
      s0_ch    <= 1'b0;
      s0_dat   <= '0;
      r_hold_q <= '0;
    end else if (in_valid_i) begin
      s0_vld   <= 1'b1;
      s0_ch    <= 1'b0;
      s0_dat   <= in_l_i;
      r_hold_q <= in_r_i;
    end else if (s0_vld && !s0_ch) begin
      s0_vld   <= 1'b1;
      s0_ch    <= 1'b1;
      s0_dat   <= r_hold_q;
    end else begin
      s0_vld   <= 1'b0;
    end
  end

  logic                 hp_vld, hp_ch;
  logic signed [DW-1:0] hp_dat;

  deci_dc_hpf #(.IW(IN_W), .OW(DW), .SHIFT(DC_SHIFT)) u_hpf (
    .clk_i, .rst_ni, .bypass_i(dc_bypass_i),
    .vld_i(s0_vld), .ch_i(s0_ch), .dat_i(s0_dat),
    .vld_o(hp_vld), .ch_o(hp_ch), .dat_o(hp_dat));

  logic                 st_vld [NUM_HB+1];
  logic                 st_ch  [NUM_HB+1];
  logic signed [DW-1:0] st_dat [NUM_HB+1];

  deci_cic #(.W(DW), .RATIO(CIC_R), .ORDER(CIC_N)) u_cic (
    .clk_i, .rst_ni,
    .vld_i(hp_vld), .ch_i(hp_ch), .dat_i(hp_dat),
    .vld_o(st_vld[0]), .ch_o(st_ch[0]), .dat_o(st_dat[0]));

  for (genvar g = 0; g < NUM_HB; g++) begin : g_hb
    deci_halfband #(.W(DW)) u_hb (
      .clk_i, .rst_ni,
      .vld_i(st_vld[g]), .ch_i(st_ch[g]), .dat_i(st_dat[g]),
      .vld_o(st_vld[g+1]), .ch_o(st_ch[g+1]), .dat_o(st_dat[g+1]));
  end

  logic signed [OUT_W-1:0] l_hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l_hold_q    <= '0;
      out_valid_o <= 1'b0;
      out_l_o     <= '0;
      out_r_o     <= '0;
    end else begin
      out_valid_o <= 1'b0;
      if (st_vld[NUM_HB]) begin
        if (!st_ch[NUM_HB]) begin
          l_hold_q <= sat(st_dat[NUM_HB]);
        end else begin
          out_l_o     <= l_hold_q;
          out_r_o     <= sat(st_dat[NUM_HB]);
          out_valid_o <= 1'b1;
        end
      end
    end
  end

  p_in_gap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> !in_valid_i);

  p_out_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);
endmodule

// File: tb/deci_chain_tb.sv
module deci_chain_tb_top;
  localparam int NV   = 7;
  localparam int NSTB = 4096;
  // bypass, left level, right level, alternate sign, exact(1)/tolerance(0)
  localparam int V_BYP [NV] = '{1, 1, 1, 1, 0, 0, 1};
  localparam int V_L   [NV] = '{1000, -8388608, 8388607, 5000000, 3000000, -8388608, 123};
  localparam int V_R   [NV] = '{-2000, 8388607, -8388608, -3000000, -4000000, 8388607, -1};
  localparam int V_ALT [NV] = '{0, 0, 0, 1, 0, 0, 0};
  localparam int V_EXA [NV] = '{1, 1, 1, 1, 0, 0, 1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byp = 1'b1;
  logic in_vld = 1'b0;
  logic signed [23:0] in_l = '0, in_r = '0;
  logic out_vld;
  logic signed [23:0] out_l, out_r;

  always #4 clk = ~clk;

  deci_chain #(.DC_SHIFT(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .dc_bypass_i(byp), .in_valid_i(in_vld),
    .in_l_i(in_l), .in_r_i(in_r), .out_valid_o(out_vld),
    .out_l_o(out_l), .out_r_o(out_r));

  int n_chk = 0, n_fail = 0;
  int n_stb = 0, n_pulse = 0;
  time blk_time = 0;
  int last_l = 0, last_r = 0;
  bit watch = 1'b0, pos_l = 1'b0, neg_r = 1'b0, wrap_seen = 1'b0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // output monitor: R3 timing, R7 wrap watch
  always @(negedge clk) begin
    if (rst_n && out_vld) begin
      n_pulse++;
      chk(($time - blk_time) == 64, "R3 pulse delay (ns)", longint'($time - blk_time), 64);
      last_l = int'(out_l);
      last_r = int'(out_r);
      if (watch) begin
        if (pos_l && out_l < 0) wrap_seen = 1'b1;
        if (neg_r && out_r > 0) wrap_seen = 1'b1;
        if (out_l > 0) pos_l = 1'b1;
        if (out_r < 0) neg_r = 1'b1;
      end
    end
  end

  task automatic strobe(input int l, input int r);
    @(negedge clk);
    in_vld = 1'b1;
    in_l = 24'(l);
    in_r = 24'(r);
    n_stb++;
    if (n_stb % 128 == 0) blk_time = $time;
    @(negedge clk);
    in_vld = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(out_vld == 1'b0, "R1 valid in reset", out_vld, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_vld == 1'b0, "R1 valid after reset", out_vld, 0);
    chk(out_l == 0, "R1 left after reset", out_l, 0);
    chk(out_r == 0, "R1 right after reset", out_r, 0);

    for (int v = 0; v < NV; v++) begin
      byp = V_BYP[v][0];
      watch = (v == 2);
      pos_l = 1'b0;
      neg_r = 1'b0;
      for (int k = 0; k < NSTB; k++) begin
        if (V_ALT[v] != 0 && (k % 2) == 1) strobe(-V_L[v], -V_R[v]);
        else strobe(V_L[v], V_R[v]);
      end
      repeat (10) @(negedge clk);
      if (V_ALT[v] != 0) begin
        chk(last_l == 0, "R6 left nyquist", last_l, 0);
        chk(last_r == 0, "R6 right nyquist", last_r, 0);
      end else if (V_EXA[v] != 0) begin
        chk(last_l == V_L[v], "R4 R8 left level", last_l, V_L[v]);
        chk(last_r == V_R[v], "R4 R8 right level", last_r, V_R[v]);
      end else begin
        chk(last_l <= 300 && last_l >= -300, "R5 left dc removed", last_l, 0);
        chk(last_r <= 300 && last_r >= -300, "R5 right dc removed", last_r, 0);
      end
      if (v == 2) chk(!wrap_seen, "R7 no wrap on full-scale step", wrap_seen, 0);
    end
    chk(n_pulse == n_stb / 128, "R2 pulse count", n_pulse, n_stb / 128);
    done = 1'b1;
    finish_run();
  end
endmodule